// File: doc/BRIEF.md
# Three-Wire-Plus-Output Serial EEPROM Model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. A host reaches it through four plain pins: a chip select, a serial clock, a serial data input and a serial data output. All four run in the system clock domain. The block watches the serial clock for rising edges and treats each one as a bit slot. A command opens with a 1 bit while chip select is high. A 2-bit opcode follows, then an address sent most significant bit first, then 16 data bits for the two write commands.

The decoder handles the full command set. It reads a word, writes a word, erases a word, erases every word, writes every word, and sets or clears the programming latch. Opcode 00 is not an operation by itself: the two top address bits pick one of four system commands and the rest of the address bits are ignored. Every command that changes the array is gated by the programming latch. The storage is a register array of 2^ADDR_W words, with ADDR_W set to 6 or 8.

The serial pins are bit-level control lines, so they carry no valid/ready handshake. The host sets the pace through the serial clock, and the block never stalls it.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high and no command is active, data-in bits of 0 sampled at serial clock rising edges are ignored. The first 1 is the start bit.
- R2: READ uses opcode 10. After the last address bit, data out shows one 0 bit. Each later serial clock rising edge then shifts out the next bit of the addressed word, bit 15 first, and 0 follows once bit 0 has been shifted out.
- R3: WRITE uses opcode 01 followed by 16 data bits, most significant first. The addressed word takes that value once the 16th data bit has been sampled with chip select still high.
- R4: ERASE uses opcode 11 and sets the addressed word to 16'hFFFF.
- R5: Opcode 00 with top address bits 10 erases all: every word becomes 16'hFFFF.
- R6: Opcode 00 with top address bits 01, followed by 16 data bits, writes that value into every word.
- R7: Opcode 00 with top address bits 11 sets the programming latch, and top address bits 00 clear it. Reset clears it. While it is clear, WRITE, ERASE, erase-all and write-all leave the array unchanged.
- R8: Dropping chip select abandons a partly received command, which then has no effect, and returns the decoder to waiting for a start bit. Data out is 0 whenever chip select is low.
- R9: After reset, data out is 0 and every word reads as 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; its rising edges mark bit slots |
| di | input | 1 | Serial data in, sampled at serial clock rising edges |
| dout | output | 1 | Serial data out |

## Verification
Several corner cases are targeted. Leading zeros before the start bit check that a decoder which accepts any bit as the start would not misread the opcode. A write cut short by dropping chip select after half its data bits checks that a design committing early would corrupt the word. Every programming command is issued with the latch cleared, which exposes a design that gates only single-word writes. A read stopped mid-word checks that data out falls to 0 and does not keep shifting. Random commands against a bench-side word model catch off-by-one shifts and a missing or doubled dummy bit, because either one moves every read value by one bit.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_SYS   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    SUB_LOCK  = 2'b00,
    SUB_FILL  = 2'b01,
    SUB_CLEAR = 2'b10,
    SUB_ARM   = 2'b11
  } sys_sub_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } dec_state_e;

endpackage

// File: rtl/mw_eeprom_edge.sv
module mw_eeprom_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  output logic sk_rise
);
  logic sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  assign sk_rise = sk & ~sk_q;
endmodule

// File: rtl/mw_eeprom_decoder.sv
module mw_eeprom_decoder
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                di,
  input  logic                sk_rise,
  output logic                reading,
  output logic                rd_load,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic                wen,
  output logic                cmd_wr,
  output logic                cmd_all,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [WORD_W-1:0]   cmd_data
);
  localparam int CNT_W = 5;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);

  dec_state_e          state;
  logic [CNT_W-1:0]    cnt;
  logic [1:0]          op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   data_q;
  logic [ADDR_W-1:0]   addr_nx;
  logic [WORD_W-1:0]   data_nx;
  sys_sub_e            sub_nx;

  assign addr_nx = {addr_q[ADDR_W-2:0], di};
  assign data_nx = {data_q[WORD_W-2:0], di};
  assign sub_nx  = sys_sub_e'(addr_nx[ADDR_W-1 -: 2]);
  assign reading = (state == ST_READ);
  assign rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      wen      <= 1'b0;
      rd_load  <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_all  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      rd_load <= 1'b0;
      cmd_wr  <= 1'b0;
      cmd_all <= 1'b0;
      if (!cs) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (sk_rise) begin
        case (state)
          ST_IDLE: begin
            if (di) begin
              state <= ST_OPC;
              cnt   <= '0;
            end
          end
          ST_OPC: begin
            op_q <= {op_q[0], di};
            if (cnt == CNT_W'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_q <= addr_nx;
            if (cnt == ADDR_LAST) begin
              cnt <= '0;
              case (opcode_e'(op_q))
                OP_READ: begin
                  state   <= ST_READ;
                  rd_load <= 1'b1;
                end
                OP_WRITE: state <= ST_DATA;
                OP_ERASE: begin
                  state    <= ST_HOLD;
                  cmd_wr   <= wen;
                  cmd_addr <= addr_nx;
                  cmd_data <= '1;
                end
                default: begin
                  case (sub_nx)
                    SUB_ARM: begin
                      wen   <= 1'b1;
                      state <= ST_HOLD;
                    end
                    SUB_LOCK: begin
                      wen   <= 1'b0;
                      state <= ST_HOLD;
                    end
                    SUB_CLEAR: begin
                      state    <= ST_HOLD;
                      cmd_wr   <= wen;
                      cmd_all  <= wen;
                      cmd_data <= '1;
                    end
                    default: state <= ST_DATA;
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            data_q <= data_nx;
            if (cnt == DATA_LAST) begin
              state    <= ST_HOLD;
              cnt      <= '0;
              cmd_wr   <= wen;
              cmd_all  <= wen & (opcode_e'(op_q) == OP_SYS);
              cmd_addr <= addr_q;
              cmd_data <= data_nx;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_array.sv
module mw_eeprom_array
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                all,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [WORD_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[g] <= '1;
        else if (wr && (all || waddr == ADDR_W'(g)))
          mem[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem[raddr];
endmodule

// File: rtl/mw_eeprom_shifter.sv
module mw_eeprom_shifter
  import mw_eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              reading,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              dout
);
  logic [WORD_W:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sr <= '0;
    else if (!cs)              sr <= '0;
    else if (load)             sr <= {1'b0, word};
    else if (sk_rise && reading) sr <= {sr[WORD_W-1:0], 1'b0};
  end

  assign dout = cs & reading & sr[WORD_W];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  logic                sk_rise;
  logic                reading;
  logic                rd_load;
  logic [ADDR_W-1:0]   rd_addr;
  logic                wen;
  logic                cmd_wr;
  logic                cmd_all;
  logic [ADDR_W-1:0]   cmd_addr;
  logic [WORD_W-1:0]   cmd_data;
  logic [WORD_W-1:0]   rd_word;

  mw_eeprom_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sk(sk), .sk_rise(sk_rise)
  );

  mw_eeprom_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .sk_rise(sk_rise),
    .reading(reading), .rd_load(rd_load), .rd_addr(rd_addr), .wen(wen),
    .cmd_wr(cmd_wr), .cmd_all(cmd_all), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data)
  );

  mw_eeprom_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .all(cmd_all),
    .waddr(cmd_addr), .wdata(cmd_data), .raddr(rd_addr), .rdata(rd_word)
  );

  mw_eeprom_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise),
    .reading(reading), .load(rd_load), .word(rd_word), .dout(dout)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic reading,
  input logic rd_load,
  input logic wen,
  input logic cmd_wr
);
  p_dout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !reading);

  p_dummy_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> !dout);

  p_locked_no_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> $past(wen));

  p_commit_in_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> $past(cs));

  p_arm_in_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> $past(cs));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .reading(reading),
  .rd_load(rd_load), .wen(wen), .cmd_wr(cmd_wr)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int   nchk = 0, nerr = 0;
  logic done = 1'b0;

  logic [15:0] exp_mem [DEPTH];
  logic        exp_wen;

  always #5 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); sk = 1'b0; di = b;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic finish_cmd();
    @(negedge clk); sk = 1'b0; cs = 1'b0; di = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Bench reference of command effects
  task automatic model(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [15:0] d);
    logic [1:0] sub = a[AW-1 -: 2];
    case (op)
      2'b01: if (exp_wen) exp_mem[a] = d;
      2'b11: if (exp_wen) exp_mem[a] = 16'hFFFF;
      2'b00: case (sub)
        2'b11: exp_wen = 1'b1;
        2'b00: exp_wen = 1'b0;
        2'b10: if (exp_wen) for (int k = 0; k < DEPTH; k++) exp_mem[k] = 16'hFFFF;
        default: if (exp_wen) for (int k = 0; k < DEPTH; k++) exp_mem[k] = d;
      endcase
      default: ;
    endcase
  endtask

  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [15:0] d, input int lead);
    logic has_data = (op == 2'b01) || (op == 2'b00 && a[AW-1 -: 2] == 2'b01);
    @(negedge clk); cs = 1'b1;
    for (int i = 0; i < lead; i++) bit_out(1'b0);
    bit_out(1'b1);
    send({30'd0, op}, 2);
    send({{(32-AW){1'b0}}, a}, AW);
    if (has_data) send({16'd0, d}, 16);
    finish_cmd();
    if (op != 2'b10) model(op, a, d);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input string tag);
    logic [15:0] v = '0;
    @(negedge clk); cs = 1'b1;
    bit_out(1'b1);
    send(32'd2, 2);
    send({{(32-AW){1'b0}}, a}, AW);
    check(dout == 1'b0, {tag, " dummy R2"}, {15'd0, dout}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      bit_out(1'b0);
      v[i] = dout;
    end
    finish_cmd();
    check(v == exp_mem[a], tag, v, exp_mem[a]);
  endtask

  function automatic logic [AW-1:0] sys_addr(input logic [1:0] sub);
    return {sub, {(AW-2){1'b0}}};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4711));
    for (int k = 0; k < DEPTH; k++) exp_mem[k] = 16'hFFFF;
    exp_wen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout == 1'b0, "R9 reset dout", {15'd0, dout}, 16'd0);
    read_chk(6'd5, "R9 erased after reset");

    // R7: programming locked after reset
    cmd(2'b01, 6'd3, 16'h1234, 0);
    read_chk(6'd3, "R7 write while locked");

    // R7 arm, R1 leading zeros, R3 write
    cmd(2'b00, sys_addr(2'b11), 16'h0, 2);
    cmd(2'b01, 6'd3, 16'hA5C3, 3);
    read_chk(6'd3, "R1 R3 write after leading zeros");

    cmd(2'b11, 6'd3, 16'h0, 0);
    read_chk(6'd3, "R4 erase word");

    cmd(2'b00, sys_addr(2'b01), 16'h5A5A, 0);
    read_chk(6'd0, "R6 write all lo");
    read_chk(6'(DEPTH - 1), "R6 write all hi");

    cmd(2'b00, sys_addr(2'b10), 16'h0, 1);
    read_chk(6'd9, "R5 erase all");

    // R8: aborted write leaves word intact
    cmd(2'b01, 6'd7, 16'h1357, 0);
    @(negedge clk); cs = 1'b1;
    bit_out(1'b1); send(32'd1, 2); send(32'd7, AW); send(32'h00FF, 8);
    finish_cmd();
    read_chk(6'd7, "R8 aborted write");

    // R8: data out drops with chip select mid-read
    @(negedge clk); cs = 1'b1;
    bit_out(1'b1); send(32'd2, 2); send(32'd8, AW);
    bit_out(1'b0);
    check(dout == 1'b1, "R2 first data bit", {15'd0, dout}, 16'd1);
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    check(dout == 1'b0, "R8 dout low with cs low", {15'd0, dout}, 16'd0);
    finish_cmd();

    // R2: after the LSB the output stays 0
    @(negedge clk); cs = 1'b1;
    bit_out(1'b1); send(32'd2, 2); send(32'd8, AW);
    for (int i = 0; i < 17; i++) bit_out(1'b0);
    check(dout == 1'b0, "R2 zero after word", {15'd0, dout}, 16'd0);
    finish_cmd();

    // R7: lock again, every programming command ignored
    cmd(2'b00, sys_addr(2'b00), 16'h0, 0);
    cmd(2'b01, 6'd9, 16'h0000, 0);
    cmd(2'b11, 6'd7, 16'h0, 0);
    cmd(2'b00, sys_addr(2'b10), 16'h0, 0);
    cmd(2'b00, sys_addr(2'b01), 16'h0000, 0);
    read_chk(6'd7, "R7 locked erase/eral/wral");
    read_chk(6'd9, "R7 locked write");

    // Random mix
    cmd(2'b00, sys_addr(2'b11), 16'h0, 0);
    for (int n = 0; n < 220; n++) begin
      int sel = $urandom % 20;
      logic [AW-1:0] a = AW'($urandom);
      logic [15:0]   d = 16'($urandom);
      int lead = $urandom % 3;
      if (sel < 7)       cmd(2'b01, a, d, lead);
      else if (sel < 13) read_chk(a, "R2 R3 random read");
      else if (sel < 15) cmd(2'b11, a, d, lead);
      else if (sel == 15) cmd(2'b00, sys_addr(2'b11), d, lead);
      else if (sel == 16) cmd(2'b00, sys_addr(2'b00), d, lead);
      else if (sel == 17) cmd(2'b00, sys_addr(2'b10), d, lead);
      else if (sel == 18) cmd(2'b00, sys_addr(2'b01), d, lead);
      else               cmd(2'b00, {2'b11, a[AW-3:0]}, d, lead);
    end
    for (int k = 0; k < DEPTH; k += 9) read_chk(AW'(k), "R3 R5 R6 final sweep");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule